// File: doc/BRIEF.md
# Bus Wait-State Insertion Controller

This block sits between a small processor core and its external peripheral bus and decides how long each external access lasts. The core raises a request together with a register address (0 to 7) and a direction. The block answers each cycle with either a stall, which holds the core, or a completion strobe, which ends the access.

A 16-bit configuration word chooses, for every register address and separately for reads and writes, whether one automatic wait state is added. A slow peripheral can stretch the access further by holding the active-low ready input high. Ready is sampled only while a request is present and only after the automatic wait state has elapsed. The configuration is written through a load strobe and comes out of reset with every wait disabled.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset the configuration is all zero, so an access with `rdy_n` low completes in its first cycle.
- R2: `cfg_data` is captured on the clock edge where `cfg_load` is high. Bit n (0..7) enables the automatic wait for reads of address n. Bit 8+n enables it for writes of address n. `rd_nwr` = 1 marks a read.
- R3: An access whose selected enable bit is clear and that sees `rdy_n` low completes in its first cycle: `done` is high and `stall` is low in that cycle.
- R4: An access whose selected enable bit is set is stalled in its first cycle, and no more than one automatic wait state is added.
- R5: Once any automatic wait has elapsed, every cycle with `rdy_n` high adds a stalled cycle. The access completes in the first such cycle where `rdy_n` is low.
- R6: The value of `rdy_n` during the automatic wait cycle has no effect. An access with the wait enabled and `rdy_n` high only in its first cycle lasts exactly two cycles.
- R7: While `req` is low, `stall` and `done` stay low whatever `rdy_n` does, and that `rdy_n` activity does not lengthen a later access.
- R8: `stall` and `done` are never high together. `stall` is high in every inserted cycle, so an access of N cycles shows N-1 stalled cycles.
- R9: If `req` stays high after `done`, the next cycle starts a new access that is timed from its own address and direction, including a fresh automatic wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for the wait configuration |
| cfg_data | input | 16 | Wait enables: reads in [7:0], writes in [15:8] |
| req | input | 1 | External access request, held until `done` |
| addr | input | 3 | External register address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| rdy_n | input | 1 | Active-low peripheral ready |
| stall | output | 1 | Holds the core during an inserted cycle |
| done | output | 1 | Access completes in this cycle |

## Verification
The hardest case to reach is the overlap of the automatic wait with a peripheral that is not yet ready. Here the correct length depends on ready being ignored in the first cycle and sampled from the second cycle on. The bench drives ready from a per-access count of high cycles, so table rows can set that count to zero, to one (inside the automatic wait) or to several (beyond it). Back-to-back accesses with the request held high through `done` check that the automatic wait restarts for each access.

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter  int NREG = 8,
  localparam int AW   = $clog2(NREG),
  localparam int CW   = 2 * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_data,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          rd_nwr,
  input  logic          rdy_n,
  output logic          stall,
  output logic          done
);

  logic [CW-1:0]   cfg_q;
  logic            waited;
  logic [NREG-1:0] rd_en, wr_en;
  logic            sel_en, auto_wait;

  assign rd_en     = cfg_q[NREG-1:0];
  assign wr_en     = cfg_q[CW-1:NREG];
  assign sel_en    = rd_nwr ? rd_en[addr] : wr_en[addr];
  assign auto_wait = req & ~waited & sel_en;

  assign stall = req & (auto_wait | rdy_n);
  assign done  = req & ~auto_wait & ~rdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      waited <= 1'b0;
    end else begin
      if (cfg_load) cfg_q <= cfg_data;
      waited <= req & ~done;
    end
  end

endmodule

// File: rtl/bus_wait_ctrl_checker.sv
module bus_wait_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic rdy_n,
  input logic sel_en,
  input logic stall,
  input logic done
);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && done));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!stall && !done));

  a_r4_auto_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel_en && (!$past(req) || $past(done))) |-> (stall && !done));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sel_en && !rdy_n && (!$past(req) || $past(done))) |-> done);

  a_r5_ready_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall) && req && !rdy_n) |-> done);

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall) && req && rdy_n) |-> stall);

endmodule

bind bus_wait_ctrl bus_wait_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .rdy_n(rdy_n),
  .sel_en(sel_en), .stall(stall), .done(done)
);

// File: tb/bus_wait_ctrl_test.sv
module bus_wait_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        req = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_nwr = 1'b1;
  logic        rdy_n = 1'b0;
  logic        stall, done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_wait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .req(req), .addr(addr), .rd_nwr(rd_nwr), .rdy_n(rdy_n),
    .stall(stall), .done(done)
  );

  // {addr, rd, ready-high cycles, expected length}, config 16'h3CA5
  localparam logic [15:0] VEC [10] = '{
    16'h0_1_0_2, 16'h1_1_0_1, 16'h1_0_3_4, 16'h2_0_0_2, 16'h2_1_1_2,
    16'h3_0_3_4, 16'h6_1_2_3, 16'h7_1_0_2, 16'h7_0_0_1, 16'h4_0_5_6
  };

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic access(input logic [2:0] a, input logic rd, input int hi,
                        input int exp, input bit keep, input string tag);
    int len = 0, stalls = 0, both = 0;
    req = 1'b1; addr = a; rd_nwr = rd;
    for (int c = 0; c < 40; c++) begin
      rdy_n = (c < hi);
      #1;
      if (stall) stalls++;
      if (stall && done) both++;
      if (done) begin len = c + 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    if (!keep) begin req = 1'b0; rdy_n = 1'b0; end
    check(len == exp, tag, len, exp);
    check(stalls == exp - 1, "R8 stall count", stalls, exp - 1);
    check(both == 0, "R8 exclusive", both, 0);
  endtask

  task automatic load_cfg(input logic [15:0] v);
    cfg_load = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!stall && !done, "R1 reset outputs", int'({stall, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every wait disabled after reset
    access(3'd0, 1'b1, 0, 1, 0, "R1 reset config rd");
    access(3'd4, 1'b0, 0, 1, 0, "R1 reset config wr");

    // R7: idle ready activity ignored
    rdy_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(!stall && !done, "R7 idle quiet", int'({stall, done}), 0);
      @(negedge clk);
    end
    rdy_n = 1'b0;
    access(3'd5, 1'b1, 0, 1, 0, "R7 no lingering effect");

    // R2: configuration layout
    load_cfg(16'h3CA5);
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][14:12], VEC[i][8], int'(VEC[i][7:4]), int'(VEC[i][3:0]), 0,
             (VEC[i][7:4] == 0) ? ((VEC[i][3:0] == 1) ? "R3 no wait" : "R4 auto wait")
                                : ((VEC[i][3:0] == 2 && VEC[i][7:4] == 1) ? "R6 overlap"
                                                                          : "R5 ready wait"));
    end

    // R9: back-to-back with request held
    access(3'd0, 1'b1, 0, 2, 1, "R9 first");
    access(3'd0, 1'b1, 0, 2, 1, "R9 second fresh auto");
    access(3'd1, 1'b1, 0, 1, 0, "R9 third no wait");

    // R2: reload changes timing
    load_cfg(16'h0200);
    access(3'd1, 1'b0, 0, 2, 0, "R2 write bit 9");
    access(3'd0, 1'b1, 0, 1, 0, "R2 read bit 0 cleared");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule